// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a synchronous single-port memory. Its command and data phases are offset by a fixed two-cycle pipeline, so reads and writes can follow each other on the shared data path with no idle cycle between them. A command is sampled on rising edge k. Its data phase is the clock cycle that ends at edge k+2. For a read, data is driven on `dOut` with `dOe` high from just after edge k+1 until edge k+2. For a write, `dIn` is sampled at edge k+2.

The data path is modelled as separate in, out and output-enable signals, with 36-bit words made of four 9-bit lanes. A clock enable freezes the whole pipeline. Three chip enables gate new commands. A load/advance input either starts a new command or repeats the type of the last loaded command, using an address supplied from outside by a separate burst counter. An asynchronous output enable can silence the data output at any time.

Top module: `zbtSram`

## Requirements
- R1: A read loaded at edge k (advLdN=0, chips selected, rwN=1, clkEnN=0 at k and k+1) drives the word stored at its address on dOut with dOe=1 between edges k+1 and k+2.
- R2: A write loaded at edge k stores dIn, as sampled at edge k+2, into only those lanes i (bits 9i+8..9i) whose bwN[i] was 0 at edge k. The other lanes keep their old contents.
- R3: A read issued in the cycle right after a write to the same address returns the merged new word: the written lanes come from the write and the rest come from memory.
- R4: Reads and writes may alternate on consecutive edges with no idle cycle. dOe is 0 during every write data phase.
- R5: While clkEnN=1 at an edge, all synchronous inputs are ignored at that edge: no memory write takes place, and dOut and dOe keep their values.
- R6: A load (advLdN=0) with ceN1=1, ce2=0 or ceN2=1 starts no operation. dOe is 0 in its data phase, memory is unchanged, and transfers already in flight still complete.
- R7: With advLdN=1 the command repeats the type of the last load at the current addr and bwN, ignoring rwN and the chip enables. After a deselecting load, an advance does nothing.
- R8: oeN=1 forces dOe to 0 at once, without waiting for a clock edge.
- R9: While rstN=0 and until the first command reaches its data phase, dOe is 0 and dOut is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset of the pipeline |
| clkEnN | input | 1 | Active-low clock enable; high freezes the block |
| ceN1 | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ceN2 | input | 1 | Chip enable, active low |
| advLdN | input | 1 | 0 loads a new command, 1 advances (repeats the last type) |
| rwN | input | 1 | 1 selects read, 0 selects write |
| bwN | input | 4 | Active-low write enables, one per 9-bit lane |
| addr | input | ADDR_W | Word address |
| dIn | input | 36 | Write data, sampled at the data-phase edge |
| oeN | input | 1 | Asynchronous active-low output enable |
| dOut | output | 36 | Read data |
| dOe | output | 1 | Drive enable for dOut during read data phases |

## Verification
The hardest case to reach from the ports is a read whose data phase overlaps a pending write to the same address while the pipeline is frozen. In that case the output must hold the forwarded merged word across the frozen edges, and the garbage driven on the bus during the freeze must never reach memory. The stimulus issues write-then-read pairs with varied lane masks and inserts one or two frozen cycles after them. During those cycles it drives inverted commands and corrupted write data. A full readback of every address then shows that none of it landed in memory.

// File: rtl/zbtPkg.sv
`timescale 1ns/1ps
package zbtPkg;
  localparam int LANE_W    = 9;
  localparam int NUM_LANES = 4;
  localparam int WORD_W    = LANE_W * NUM_LANES;

  // strobes from the control pipeline to the storage datapath
  typedef struct packed {
    logic                 wrCommit; // stage-2 write lands this edge
    logic                 rdLoad;   // stage-1 read fills the output register
    logic                 fwd;      // committing write hits the read address
    logic [NUM_LANES-1:0] laneWe;   // lanes enabled for the committing write
  } strobe_t;
endpackage

// File: rtl/zbtCtrl.sv
`timescale 1ns/1ps
module zbtCtrl
  import zbtPkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 clkEnN,
  input  logic                 ceN1,
  input  logic                 ce2,
  input  logic                 ceN2,
  input  logic                 advLdN,
  input  logic                 rwN,
  input  logic [NUM_LANES-1:0] bwN,
  input  logic [ADDR_W-1:0]    addr,
  output strobe_t              stb,
  output logic [ADDR_W-1:0]    wrAddr,
  output logic [ADDR_W-1:0]    rdAddr,
  output logic                 drive
);
  logic step, selected, loadCmd, newValid, newRd;
  logic burstOn, burstRd;
  logic s1Valid, s1Rd, s2Valid, s2Rd;
  logic [ADDR_W-1:0] s1Addr, s2Addr;
  logic [NUM_LANES-1:0] s1Lanes, s2Lanes;

  always_comb begin
    step     = ~clkEnN;
    selected = ~ceN1 & ce2 & ~ceN2;
    loadCmd  = ~advLdN;
    newValid = loadCmd ? selected : burstOn;
    newRd    = loadCmd ? rwN : burstRd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      burstOn <= 1'b0;
      burstRd <= 1'b1;
      s1Valid <= 1'b0;
      s1Rd    <= 1'b1;
      s1Addr  <= '0;
      s1Lanes <= '0;
      s2Valid <= 1'b0;
      s2Rd    <= 1'b1;
      s2Addr  <= '0;
      s2Lanes <= '0;
    end else if (step) begin
      if (loadCmd) begin
        burstOn <= selected;
        burstRd <= rwN;
      end
      s1Valid <= newValid;
      s1Rd    <= newRd;
      s1Addr  <= addr;
      s1Lanes <= ~bwN;
      s2Valid <= s1Valid;
      s2Rd    <= s1Rd;
      s2Addr  <= s1Addr;
      s2Lanes <= s1Lanes;
    end
  end

  always_comb begin
    stb.wrCommit = step & s2Valid & ~s2Rd;
    stb.rdLoad   = step & s1Valid & s1Rd;
    stb.fwd      = stb.wrCommit & (s2Addr == s1Addr);
    stb.laneWe   = s2Lanes;
    wrAddr       = s2Addr;
    rdAddr       = s1Addr;
    drive        = s2Valid & s2Rd;
  end
endmodule

// File: rtl/zbtDatapath.sv
`timescale 1ns/1ps
module zbtDatapath
  import zbtPkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [WORD_W-1:0] dIn,
  output logic [WORD_W-1:0] dOut
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < NUM_LANES; g++) begin : gLane
    logic [LANE_W-1:0] laneMem [DEPTH];
    logic [LANE_W-1:0] wrLane, rdLane, outLane;

    assign wrLane = dIn[g*LANE_W +: LANE_W];

    always_ff @(posedge clk) begin
      if (stb.wrCommit && stb.laneWe[g]) laneMem[wrAddr] <= wrLane;
    end

    always_comb rdLane = (stb.fwd && stb.laneWe[g]) ? wrLane : laneMem[rdAddr];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)           outLane <= '0;
      else if (stb.rdLoad) outLane <= rdLane;
    end

    assign dOut[g*LANE_W +: LANE_W] = outLane;
  end
endmodule

// File: rtl/zbtSram.sv
`timescale 1ns/1ps
module zbtSram
  import zbtPkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 clkEnN,
  input  logic                 ceN1,
  input  logic                 ce2,
  input  logic                 ceN2,
  input  logic                 advLdN,
  input  logic                 rwN,
  input  logic [NUM_LANES-1:0] bwN,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [WORD_W-1:0]    dIn,
  input  logic                 oeN,
  output logic [WORD_W-1:0]    dOut,
  output logic                 dOe
);
  strobe_t stb;
  logic [ADDR_W-1:0] wrAddr, rdAddr;
  logic drive;

  zbtCtrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .clkEnN(clkEnN), .ceN1(ceN1), .ce2(ce2),
    .ceN2(ceN2), .advLdN(advLdN), .rwN(rwN), .bwN(bwN), .addr(addr),
    .stb(stb), .wrAddr(wrAddr), .rdAddr(rdAddr), .drive(drive)
  );

  zbtDatapath #(.ADDR_W(ADDR_W)) i_data (
    .clk(clk), .rstN(rstN), .stb(stb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .dIn(dIn), .dOut(dOut)
  );

  assign dOe = drive & ~oeN;
endmodule

// File: rtl/zbtSramChk.sv
`timescale 1ns/1ps
module zbtSramChk (
  input logic        clk,
  input logic        rstN,
  input logic        clkEnN,
  input logic        ceN1,
  input logic        ce2,
  input logic        ceN2,
  input logic        advLdN,
  input logic        rwN,
  input logic        oeN,
  input logic [35:0] dOut,
  input logic        dOe
);
  logic sel;
  assign sel = ~ceN1 & ce2 & ~ceN2;

  // R9
  rst_quiet_chk: assert property (@(posedge clk) !rstN |=> !dOe);

  // R8
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rstN) oeN |-> !dOe);

  // R5
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    clkEnN |=> $stable(dOut));

  // R1
  read_lat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnN && !advLdN && sel && rwN) ##1 !clkEnN |=> (dOe || oeN));

  // R4
  write_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnN && !advLdN && sel && !rwN) ##1 !clkEnN |=> !dOe);

  // R6
  desel_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnN && !advLdN && !sel) ##1 !clkEnN |=> !dOe);
endmodule

bind zbtSram zbtSramChk i_chk (
  .clk(clk), .rstN(rstN), .clkEnN(clkEnN), .ceN1(ceN1), .ce2(ce2),
  .ceN2(ceN2), .advLdN(advLdN), .rwN(rwN), .oeN(oeN), .dOut(dOut), .dOe(dOe)
);

// File: tb/test_zbtSram.sv
`timescale 1ns/100ps
module test_zbtSram;
  localparam int AW    = 6;
  localparam int DEPTH = 1 << AW;
  localparam int SLOTS = 1024;
  localparam int K_IDLE = 0, K_RD = 1, K_WR = 2;
  localparam int OP_LDRD = 0, OP_LDWR = 1, OP_DESEL = 2, OP_ADV = 3;

  logic clk = 0, rstN = 0, clkEnN = 0, ceN1 = 1, ce2 = 0, ceN2 = 1;
  logic rwN = 1, advLdN = 0, oeN = 0;
  logic [3:0] bwN = '1;
  logic [AW-1:0] addr = '0;
  logic [35:0] dIn = '0;
  logic [35:0] dOut;
  logic dOe;

  always #2 clk = ~clk;

  zbtSram #(.ADDR_W(AW)) i_zbtSram (
    .clk(clk), .rstN(rstN), .clkEnN(clkEnN), .ceN1(ceN1), .ce2(ce2),
    .ceN2(ceN2), .advLdN(advLdN), .rwN(rwN), .bwN(bwN), .addr(addr),
    .dIn(dIn), .oeN(oeN), .dOut(dOut), .dOe(dOe)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  int slotKind [SLOTS];
  int slotAddr [SLOTS];
  logic [3:0] slotBw [SLOTS];
  string slotTag [SLOTS];
  logic [35:0] model [DEPTH];
  int s = 0;
  int burst = K_IDLE;

  function automatic logic [35:0] wdata(int j);
    logic [31:0] lo;
    lo = (32'(j) * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
    return {4'(j ^ 5), lo};
  endfunction

  task automatic check(string tag, logic [36:0] act, logic [36:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic dataPhase(int j, bit frozen);
    string tag;
    if (j < 0) return;
    tag = frozen ? "R5" : slotTag[j];
    if (slotKind[j] == K_WR) begin
      if (!frozen) begin
        dIn = wdata(j);
        for (int l = 0; l < 4; l++)
          if (!slotBw[j][l]) model[slotAddr[j]][l*9 +: 9] = dIn[l*9 +: 9];
      end
      check(tag, {dOe, 36'b0}, 37'b0);
    end else begin
      if (!frozen) dIn = 36'hB_ADC0_FFEE;
      if (slotKind[j] == K_RD) check(tag, {dOe, dOut}, {1'b1, model[slotAddr[j]]});
      else check(tag, {dOe, 36'b0}, 37'b0);
    end
  endtask

  task automatic issue(int op, int a, logic [3:0] bw, string tag, int aux = 0, bit probe = 0);
    @(negedge clk);
    if (s >= SLOTS) begin
      errors++;
      $display("FAIL R1 slot table full actual %0d expected below %0d", s, SLOTS);
      return;
    end
    clkEnN = 0;
    dataPhase(s - 2, 0);
    ceN1 = 0; ce2 = 1; ceN2 = 0; advLdN = 0;
    case (op)
      OP_LDRD: begin rwN = 1; slotKind[s] = K_RD; burst = K_RD; end
      OP_LDWR: begin rwN = 0; slotKind[s] = K_WR; burst = K_WR; end
      OP_DESEL: begin
        rwN = 0;
        if (aux % 3 == 0) ceN1 = 1;
        else if (aux % 3 == 1) ce2 = 0;
        else ceN2 = 1;
        slotKind[s] = K_IDLE; burst = K_IDLE;
      end
      default: begin
        advLdN = 1; ceN1 = 1; ce2 = 0; ceN2 = 1;
        rwN = (burst == K_WR);
        slotKind[s] = burst;
      end
    endcase
    addr = AW'(a);
    bwN = bw;
    slotAddr[s] = a % DEPTH;
    slotBw[s] = bw;
    slotTag[s] = tag;
    s++;
    if (probe) begin
      oeN = 1;
      #0.5;
      check("R8", {dOe, 36'b0}, 37'b0);
      oeN = 0;
    end
  endtask

  task automatic freezeCycle();
    @(negedge clk);
    clkEnN = 1;
    advLdN = 0; ceN1 = 0; ce2 = 1; ceN2 = 0;
    rwN = ~rwN; addr = ~addr; bwN = '0;
    dIn = ~dIn ^ 36'h1_2345_6789;
    dataPhase(s - 2, 1);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    // R9: reset state
    repeat (3) @(negedge clk);
    check("R9", {dOe, dOut}, 37'b0);
    rstN = 1;
    @(negedge clk);
    check("R9", {dOe, dOut}, 37'b0);

    // R2 full writes, R1 readback of every address
    for (int a = 0; a < DEPTH; a++) issue(OP_LDWR, a, 4'b0000, "R2");
    for (int a = 0; a < DEPTH; a++) issue(OP_LDRD, a, 4'b1111, "R1");

    // R3: partial write followed at once by a read of the same address
    for (int a = 0; a < DEPTH; a++) begin
      issue(OP_LDWR, a, 4'(a), "R2");
      issue(OP_LDRD, a, 4'b1111, "R3");
    end

    // R4: read and write alternating with no idle cycle
    for (int a = 0; a < DEPTH - 1; a++) begin
      issue(OP_LDRD, a, 4'b1111, "R4");
      issue(OP_LDWR, (a + 7) % DEPTH, 4'(a + 3), "R4");
    end
    for (int a = 0; a < DEPTH; a++) issue(OP_LDRD, a, 4'b1111, "R1");

    // R5: frozen cycles in the middle of mixed traffic
    for (int i = 0; i < 40; i++) begin
      case (i % 4)
        0: issue(OP_LDWR, (i * 5) % DEPTH, 4'b0000, "R5");
        1: issue(OP_LDRD, ((i - 1) * 5) % DEPTH, 4'b1111, "R5");
        2: issue(OP_LDRD, (i * 5) % DEPTH, 4'b1111, "R5");
        default: issue(OP_LDWR, (i * 5) % DEPTH, 4'b1010, "R5");
      endcase
      if (i % 2 == 0) freezeCycle();
      if (i % 5 == 0) freezeCycle();
    end
    for (int a = 0; a < DEPTH; a++) issue(OP_LDRD, a, 4'b1111, "R5");

    // R6: each chip enable deselects while transfers are in flight
    for (int i = 0; i < 30; i++) begin
      if (i % 2 == 1) issue(OP_DESEL, i, 4'b0000, "R6", i / 2);
      else if (i % 4 == 0) issue(OP_LDRD, i, 4'b1111, "R6");
      else issue(OP_LDWR, i, 4'b0110, "R6");
    end
    for (int a = 0; a < 30; a++) issue(OP_LDRD, a, 4'b1111, "R6");

    // R7: advance repeats the last loaded type
    issue(OP_LDRD, 3, 4'b1111, "R7");
    issue(OP_ADV, 4, 4'b1111, "R7");
    issue(OP_ADV, 5, 4'b1111, "R7");
    issue(OP_LDWR, 10, 4'b0000, "R7");
    issue(OP_ADV, 11, 4'b0101, "R7");
    issue(OP_ADV, 12, 4'b0000, "R7");
    issue(OP_DESEL, 0, 4'b0000, "R7", 1);
    issue(OP_ADV, 13, 4'b0000, "R7");
    issue(OP_ADV, 14, 4'b0000, "R7");
    for (int a = 10; a < 15; a++) issue(OP_LDRD, a, 4'b1111, "R7");

    // R8: output enable drops the drive immediately
    for (int a = 0; a < 8; a++) issue(OP_LDRD, a, 4'b1111, "R1", 0, 1);

    for (int i = 0; i < 3; i++) issue(OP_DESEL, 0, 4'b1111, "R6", i);

    done = 1;
    summary();
    $finish;
  end
endmodule